// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt requests for a processor core from a group of active-low maskable lines and from one active-low nonmaskable line. Each line is synchronized to the core clock and a falling edge latches a pending flag. Software sees the flags through a small register interface and can clear them one at a time. It also sets a per-line enable mask and a global disable bit. The controller raises a request toward the core whenever a flag is pending and allowed to interrupt. The nonmaskable flag always counts as allowed.

When the core accepts the request through the take input, the controller picks the most urgent source. It clears that source's pending flag and sets the global disable bit. In the following cycle it drives the source's vector address and pulses the acknowledge strobe for one cycle, which is the cycle in which the core fetches from that vector. A set global disable bit blocks all further maskable interrupts until software clears it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask register (address 0) reads 0, the flag register (address 1) reads 0, the status register (address 2) reads 0x0200 (global disable bit 9 set), and both `irq_req_o` and `ack_o` are low.
- R2: A falling edge on maskable line k (`irq_n_i[k]`) sets flag bit k within four clock cycles. A line held low does not set its flag again once the flag is cleared, and a rising edge sets nothing.
- R3: A flag is latched whatever its mask bit is (mask register bit k enables line k). A pending maskable flag drives `irq_req_o` only while its mask bit is 1.
- R4: While status bit 9 is 1, no maskable flag drives `irq_req_o`, and the flags stay readable.
- R5: Among enabled pending maskable lines the lowest index wins. Its vector is `VEC_BASE + k*VEC_STRIDE`, which is 2, 4, 6, 8 for k = 0..3 with the defaults.
- R6: A falling edge on `nmi_n_i` sets a pending bit (flag register bit 8, read-only) that raises `irq_req_o` regardless of mask and bit 9. It outranks every maskable line, and its vector is `NMI_VEC` (0x0024 by default).
- R7: When `irq_take_i` is high while `irq_req_o` is high, `ack_o` is high in the next cycle only, with `vec_o` holding the chosen vector. The chosen pending bit is cleared and status bit 9 is set, and the set wins over a status write in the same cycle.
- R8: Writing the flag register clears every flag whose data bit is 1 and leaves the flags whose data bit is 0.
- R9: If a flag is set by an edge in the same cycle that software or a take clears it, the flag ends up set.
- R10: `irq_take_i` while `irq_req_o` is low produces no acknowledge and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n_i | input | N_IRQ | Maskable request lines, active low, asynchronous |
| nmi_n_i | input | 1 | Nonmaskable request line, active low, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mask, 1 flags, 2 status |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` (combinational) |
| irq_req_o | output | 1 | An allowed interrupt is pending |
| irq_take_i | input | 1 | Core accepts the pending interrupt |
| vec_o | output | VEC_W | Vector address of the last accepted interrupt |
| ack_o | output | 1 | One-cycle acknowledge during the vector fetch |

## Verification
The assertions assume that `irq_take_i` is raised only while the core actually wants an interrupt, and that a status write does not land in the same cycle as a take whose outcome it would confuse. The stimulus drives every input half a cycle away from the sampling edge. It releases the take strobe in the cycle the acknowledge appears, so that two takes never run back to back. The interrupt lines move slowly compared with the clock, with each level held for several cycles so that the synchronizers see clean edges. The one same-cycle collision is arranged on purpose by counting the synchronizer stages, to exercise R9.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int REG_W     = 16;
    localparam int ADDR_W    = 2;
    localparam int GMODE_BIT = 9;
    localparam int NMI_BIT   = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK   = 2'd0,
        RA_FLAGS  = 2'd1,
        RA_STATUS = 2'd2
    } reg_addr_e;

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_n_i,
    output logic [W-1:0] fall_o
);

    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES-1:0] sync_d, sync_q;
        logic              prev_d, prev_q;

        always_comb begin
            sync_d = {sync_q[STAGES-2:0], line_n_i[g]};
            prev_d = sync_q[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= '1;
                prev_q <= 1'b1;
            end else begin
                sync_q <= sync_d;
                prev_q <= prev_d;
            end
        end

        assign fall_o[g] = prev_q & ~sync_q[STAGES-1];
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int              N_IRQ      = 4,
    parameter int              SYNC_STG   = 2,
    parameter int              VEC_W      = 16,
    parameter logic [VEC_W-1:0] VEC_BASE  = 16'h0002,
    parameter logic [VEC_W-1:0] VEC_STRIDE = 16'h0002,
    parameter logic [VEC_W-1:0] NMI_VEC   = 16'h0024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_n_i,
    input  logic              nmi_n_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              irq_req_o,
    input  logic              irq_take_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic              ack_o
);

    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    typedef struct packed {
        logic [N_IRQ-1:0] mask;
        logic [N_IRQ-1:0] flag;
        logic             nmi;
        logic             gmode;
        logic             ack;
        logic [VEC_W-1:0] vec;
    } state_t;

    state_t st_d, st_q;

    logic [N_IRQ:0]   fall_all;
    logic [N_IRQ-1:0] fall_m;
    logic             fall_nmi;
    logic [N_IRQ-1:0] enabled;
    logic             pick_vld;
    logic [IDX_W-1:0] pick_idx;
    logic             take_ok;
    logic             take_nmi;
    logic [N_IRQ-1:0] take_clr;
    logic [N_IRQ-1:0] sw_clr;
    logic [VEC_W-1:0] sel_vec;
    logic             wr_mask, wr_flags, wr_status;

    irq_edge_sync #(.W(N_IRQ + 1), .STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n_i ({nmi_n_i, irq_n_i}),
        .fall_o   (fall_all)
    );

    assign fall_m   = fall_all[N_IRQ-1:0];
    assign fall_nmi = fall_all[N_IRQ];
    assign enabled  = st_q.flag & st_q.mask;

    irq_prio_pick #(.N(N_IRQ), .IDX_W(IDX_W)) u_pick (
        .req_i   (enabled),
        .valid_o (pick_vld),
        .idx_o   (pick_idx)
    );

    always_comb begin
        wr_mask   = reg_wr_i && (reg_addr_i == RA_MASK);
        wr_flags  = reg_wr_i && (reg_addr_i == RA_FLAGS);
        wr_status = reg_wr_i && (reg_addr_i == RA_STATUS);

        irq_req_o = st_q.nmi | (~st_q.gmode & pick_vld);
        take_ok   = irq_take_i & irq_req_o;
        take_nmi  = take_ok & st_q.nmi;

        take_clr = '0;
        if (take_ok && !st_q.nmi) take_clr[pick_idx] = 1'b1;
        sw_clr = wr_flags ? reg_wdata_i[N_IRQ-1:0] : '0;

        sel_vec = st_q.nmi ? NMI_VEC
                           : VEC_BASE + VEC_W'(pick_idx) * VEC_STRIDE;

        st_d      = st_q;
        st_d.ack  = take_ok;
        if (wr_mask) st_d.mask = reg_wdata_i[N_IRQ-1:0];
        st_d.flag = (st_q.flag & ~sw_clr & ~take_clr) | fall_m;
        st_d.nmi  = (st_q.nmi & ~take_nmi) | fall_nmi;
        if (wr_status) st_d.gmode = reg_wdata_i[GMODE_BIT];
        if (take_ok) begin
            st_d.gmode = 1'b1;
            st_d.vec   = sel_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.gmode <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            RA_MASK:   reg_rdata_o[N_IRQ-1:0] = st_q.mask;
            RA_FLAGS: begin
                reg_rdata_o[N_IRQ-1:0] = st_q.flag;
                reg_rdata_o[NMI_BIT]   = st_q.nmi;
            end
            RA_STATUS: reg_rdata_o[GMODE_BIT] = st_q.gmode;
            default:   reg_rdata_o = '0;
        endcase
    end

    assign vec_o = st_q.vec;
    assign ack_o = st_q.ack;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int               N_IRQ   = 4,
    parameter int               VEC_W   = 16,
    parameter logic [VEC_W-1:0] NMI_VEC = 16'h0024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_take_i,
    input logic             irq_req_o,
    input logic             ack_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             gmode,
    input logic             nmi,
    input logic [N_IRQ-1:0] flag,
    input logic [N_IRQ-1:0] mask,
    input logic [N_IRQ-1:0] fall_m
);

    AST_ACK_FROM_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(irq_take_i && irq_req_o)); // R7

    AST_GMODE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> gmode); // R7

    AST_GMODE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (gmode && !nmi) |-> !irq_req_o); // R4

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (nmi || ((flag & mask) != '0))); // R3

    AST_NMI_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> irq_req_o); // R6

    AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && $past(nmi)) |-> (vec_o == NMI_VEC)); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_m != '0) |=> (($past(fall_m) & ~flag) == '0)); // R9

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .N_IRQ   (N_IRQ),
    .VEC_W   (VEC_W),
    .NMI_VEC (NMI_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_take_i (irq_take_i),
    .irq_req_o  (irq_req_o),
    .ack_o      (ack_o),
    .vec_o      (vec_o),
    .gmode      (st_q.gmode),
    .nmi        (st_q.nmi),
    .flag       (st_q.flag),
    .mask       (st_q.mask),
    .fall_m     (fall_m)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_n = 4'hF;
    logic        nmi_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_req;
    logic        irq_take = 1'b0;
    logic [15:0] vec;
    logic        ack;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .nmi_n_i(nmi_n),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_req_o(irq_req), .irq_take_i(irq_take),
        .vec_o(vec), .ack_o(ack)
    );

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic check_reg(string req, logic [1:0] a, logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    // driver: take the interrupt, push the vector expected by the requirements
    task automatic take(logic [15:0] exp_vec);
        exp_q.push_back(exp_vec);
        irq_take = 1'b1;
        cyc(1);
        irq_take = 1'b0;
        check("R7 ack pulse", {15'd0, ack}, 16'd1);
        cyc(1);
        check("R7 ack single", {15'd0, ack}, 16'd0);
    endtask

    task automatic edge_line(int k);
        irq_n[k] = 1'b0;
        cyc(6);
        irq_n[k] = 1'b1;
        cyc(4);
    endtask

    // monitor: pop and compare vectors on acknowledge
    always @(negedge clk) begin
        if (rst_n && ack) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7/R10: unexpected ack, vec %h expected none", vec);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (vec !== e) begin
                    errors++;
                    $display("FAIL R5/R6 vector: got %h expected %h", vec, e);
                end
            end
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1
        check_reg("R1 mask", 2'd0, 16'h0000);
        check_reg("R1 flags", 2'd1, 16'h0000);
        check_reg("R1 status", 2'd2, 16'h0200);
        check("R1 req", {15'd0, irq_req}, 16'd0);
        check("R1 ack", {15'd0, ack}, 16'd0);

        // R2: falling edge on line 2, hold low
        irq_n[2] = 1'b0;
        cyc(4);
        check_reg("R2 edge sets flag", 2'd1, 16'h0004);
        // R8: writing 0 leaves flag
        wr(2'd1, 16'h0000);
        check_reg("R8 zero keeps", 2'd1, 16'h0004);
        wr(2'd1, 16'h0004);
        cyc(4);
        check_reg("R2 level no reset", 2'd1, 16'h0000);
        irq_n[2] = 1'b1;
        cyc(4);
        check_reg("R2 rising no set", 2'd1, 16'h0000);
        edge_line(2);

        // R3: mask off, global enabled
        wr(2'd2, 16'h0000);
        check_reg("R3 flag latched while masked", 2'd1, 16'h0004);
        check("R3 masked no req", {15'd0, irq_req}, 16'd0);
        wr(2'd0, 16'h0004);
        check("R3 enabled req", {15'd0, irq_req}, 16'd1);

        // R4
        wr(2'd2, 16'h0200);
        check("R4 gmode blocks", {15'd0, irq_req}, 16'd0);
        check_reg("R4 flags visible", 2'd1, 16'h0004);

        // R5: lines 1 and 3 too, lowest pending index 1 wins
        edge_line(1);
        edge_line(3);
        wr(2'd0, 16'h000F);
        wr(2'd2, 16'h0000);
        check("R5 req", {15'd0, irq_req}, 16'd1);
        take(16'h0004);
        check_reg("R7 flag cleared", 2'd1, 16'h000C);
        check_reg("R7 gmode set", 2'd2, 16'h0200);

        // R10: take with no request
        irq_take = 1'b1;
        cyc(1);
        irq_take = 1'b0;
        check("R10 no ack", {15'd0, ack}, 16'd0);
        check_reg("R10 flags same", 2'd1, 16'h000C);

        // R6: NMI with gmode set and mask cleared
        wr(2'd0, 16'h0000);
        edge_line(4'd0 + 0 == 0 ? 0 : 0); // line 0 pending, masked
        nmi_n = 1'b0;
        cyc(4);
        nmi_n = 1'b1;
        check_reg("R6 nmi pending bit", 2'd1, 16'h010D);
        check("R6 nmi req", {15'd0, irq_req}, 16'd1);
        take(16'h0024);
        check_reg("R6 nmi cleared", 2'd1, 16'h000D);

        // R9: set and clear of line 1 in the same cycle
        irq_n[1] = 1'b0;
        cyc(2);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0002;
        cyc(1);
        reg_wr = 1'b0;
        check_reg("R9 set wins", 2'd1, 16'h000F);
        irq_n[1] = 1'b1;
        cyc(4);

        // R5: lowest index 0 wins among 0..3
        wr(2'd0, 16'h000F);
        wr(2'd2, 16'h0000);
        take(16'h0002);
        check_reg("R5 idx0 cleared", 2'd1, 16'h000E);

        // R6: NMI outranks pending maskable lines
        wr(2'd2, 16'h0000);
        nmi_n = 1'b0;
        cyc(4);
        nmi_n = 1'b1;
        take(16'h0024);
        check_reg("R6 maskables untouched", 2'd1, 16'h000E);

        cyc(3);
        check("R7 queue drained", 16'(exp_q.size()), 16'd0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule